// File: doc/BRIEF.md
# Secure-clear watchdog timer

This block is a watchdog that counts down once per clock. When the count runs out, it asks the system to reset. Software keeps it from expiring by writing to a clear register before the count reaches zero. The clear can work in two modes:

- **Plain mode:** any clear write restarts the count.
- **Keyed mode:** the written byte must equal the next state of an internal 8-bit LFSR. A wrong byte raises a reset request at once, even if plenty of count remains.

The LFSR is seeded through its own register, and it cannot be read back through any port. A seed of zero would freeze the LFSR, so writing zero is treated as a fault.

The block has a single write-only register port with four addresses: reload value, control, seed and clear key. It produces a one-cycle reset request and a sticky two-bit cause flag, which records whether a timeout, a key fault, or both have occurred since the block was last reset. A current-count output lets system code see how much time is left. Clock prescaling and distribution of the reset are handled outside the block.

Top module: `wdt_secure_clear`

## Requirements
- R1: After synchronous reset `rst_i`:
  - `rst_req_o` is 0, `cause_o` is 0 and `count_o` is 0.
  - The timer is disabled and in plain mode.
- R2: A write to address 1 with data bit 0 set, while the timer is disabled, enables it and loads the count from the reload register (address 0). While enabled, the count drops by one every clock.
- R3: At a clock edge where the timer is enabled and the count is 0, a reset request is raised and `cause_o` bit 0 (timeout) is set. The count is reloaded from the reload register at that same edge.
- R4: `rst_req_o` is high for exactly one cycle per event. It is never high in two consecutive cycles.
- R5: In plain mode (address 1, bit 1 = 0), any write to address 3 while enabled reloads the count. No data value causes a reset.
- R6: In keyed mode (address 1, bit 1 = 1), a write to address 3 compares data bits 7:0 with the next LFSR state. The LFSR uses x^8+x^6+x^5+x^4+1: it shifts left, and the new bit 0 is b7^b5^b4^b3. A match reloads the count and advances the LFSR by one step.
- R7: In keyed mode, a non-matching write to address 3 while enabled has three effects:
  - `rst_req_o` is raised at the next edge and `cause_o` bit 1 (key fault) is set, even with a nonzero count.
  - The LFSR does not advance.
  - The count is not reloaded.
- R8: A write to address 2 with nonzero bits 7:0 loads that value as the LFSR state. A zero value is not loaded. Instead it raises a reset request with `cause_o` bit 1, whether or not the timer is enabled.
- R9: While disabled, the count holds its value and no timeout occurs. Clear writes have no effect: no reload, no reset request and no LFSR step.
- R10: The `cause_o` bits accumulate and stay set until `rst_i`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register address: 0 reload, 1 control, 2 seed, 3 clear key |
| wr_data_i | input | 16 | Write data |
| rst_req_o | output | 1 | One-cycle system reset request |
| cause_o | output | 2 | Sticky cause: bit 0 timeout, bit 1 key fault |
| count_o | output | 16 | Current count value |

## Verification
A corrupted LFSR state shows up at the very next keyed clear: the expected key would be rejected, and a reset request would appear one edge after the write. This is why the bench follows a rejected replay with the correct key. If a mismatch wrongly advanced the LFSR, the correct key would then fail in the same way.

A counter that loads, decrements or holds wrongly is visible on `count_o` in the same cycle. Its effect on timeout timing is visible one edge after the count reaches zero.

A lost or doubled pulse, or a cleared cause bit, is visible at the edge where the event occurs.

// File: rtl/wdt_sc_pkg.sv
package wdt_sc_pkg;

    localparam int KEY_W = 8;

    typedef enum logic [1:0] {
        ADDR_RELOAD = 2'd0,
        ADDR_CTRL   = 2'd1,
        ADDR_SEED   = 2'd2,
        ADDR_KEY    = 2'd3
    } wdt_addr_e;

    typedef struct packed {
        logic keyed;
        logic enable;
    } wdt_ctrl_t;

    typedef struct packed {
        logic key_fault;
        logic timeout;
    } wdt_cause_t;

    // One step of x^8 + x^6 + x^5 + x^4 + 1, shifting toward the MSB.
    function automatic logic [KEY_W-1:0] lfsr_step(input logic [KEY_W-1:0] s);
        logic fb;
        fb = s[7] ^ s[5] ^ s[4] ^ s[3];
        return {s[KEY_W-2:0], fb};
    endfunction

endpackage

// File: rtl/wdt_sc_regs.sv
module wdt_sc_regs
    import wdt_sc_pkg::*;
#(
    parameter int CNT_W      = 16,
    parameter int RELOAD_RST = 16'hFFFF
) (
    input  logic                 clk_i,
    input  logic                 rst_i,
    input  logic                 wr_en_i,
    input  logic [1:0]           wr_addr_i,
    input  logic [CNT_W-1:0]     wr_data_i,
    output logic [CNT_W-1:0]     reload_o,
    output wdt_ctrl_t            ctrl_o,
    output logic                 start_o,
    output logic                 seed_we_o,
    output logic                 key_we_o,
    output logic                 plain_clear_o,
    output logic [KEY_W-1:0]     byte_o
);

    wdt_addr_e       addr;
    logic [CNT_W-1:0] reload_q;
    wdt_ctrl_t       ctrl_q;
    wdt_ctrl_t       ctrl_d;
    logic            ctrl_we;
    logic            clear_we;

    assign addr     = wdt_addr_e'(wr_addr_i);
    assign ctrl_we  = wr_en_i && (addr == ADDR_CTRL);
    assign clear_we = wr_en_i && (addr == ADDR_KEY) && ctrl_q.enable;
    assign ctrl_d   = '{keyed: wr_data_i[1], enable: wr_data_i[0]};

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            reload_q <= CNT_W'(RELOAD_RST);
            ctrl_q   <= '0;
        end else begin
            if (wr_en_i && addr == ADDR_RELOAD)
                reload_q <= wr_data_i;
            if (ctrl_we)
                ctrl_q <= ctrl_d;
        end
    end

    assign start_o       = ctrl_we && ctrl_d.enable && !ctrl_q.enable;
    assign seed_we_o     = wr_en_i && (addr == ADDR_SEED);
    assign key_we_o      = clear_we && ctrl_q.keyed;
    assign plain_clear_o = clear_we && !ctrl_q.keyed;
    assign byte_o        = wr_data_i[KEY_W-1:0];
    assign reload_o      = reload_q;
    assign ctrl_o        = ctrl_q;

    // R2: a start strobe leaves the timer enabled
    assert_start_enables_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        start_o |=> ctrl_o.enable);

endmodule

// File: rtl/wdt_sc_keygen.sv
module wdt_sc_keygen
    import wdt_sc_pkg::*;
#(
    parameter logic [KEY_W-1:0] SEED_RST = 8'h01
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             seed_we_i,
    input  logic             key_we_i,
    input  logic [KEY_W-1:0] byte_i,
    output logic             key_ok_o,
    output logic             key_fault_o
);

    logic [KEY_W-1:0] state_q;
    logic [KEY_W-1:0] expect_key;
    logic             seed_zero;
    logic             key_match;

    assign expect_key  = lfsr_step(state_q);
    assign seed_zero   = seed_we_i && (byte_i == '0);
    assign key_match   = (byte_i == expect_key);
    assign key_ok_o    = key_we_i && key_match;
    assign key_fault_o = seed_zero || (key_we_i && !key_match);

    always_ff @(posedge clk_i) begin
        if (rst_i)
            state_q <= SEED_RST;
        else if (seed_we_i && !seed_zero)
            state_q <= byte_i;
        else if (key_ok_o)
            state_q <= expect_key;
    end

    // R8: the state never takes the lock-up value
    assert_state_nonzero_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        state_q != '0);

    // R6: an accepted key advances exactly one step
    assert_key_advances_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        key_ok_o && !seed_we_i |=> state_q == lfsr_step($past(state_q)));

    // R7: a rejected key leaves the state alone
    assert_reject_holds_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        key_we_i && !key_ok_o |=> $stable(state_q));

endmodule

// File: rtl/wdt_sc_counter.sv
module wdt_sc_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             en_i,
    input  logic             load_i,
    input  logic [CNT_W-1:0] reload_i,
    output logic [CNT_W-1:0] count_o,
    output logic             timeout_o
);

    logic [CNT_W-1:0] count_q;
    logic             at_zero;

    assign at_zero   = (count_q == '0);
    assign timeout_o = en_i && at_zero && !load_i;

    always_ff @(posedge clk_i) begin
        if (rst_i)
            count_q <= '0;
        else if (load_i || timeout_o)
            count_q <= reload_i;
        else if (en_i)
            count_q <= count_q - 1'b1;
    end

    assign count_o = count_q;

    // R9: disabled counter without a load holds
    assert_hold_when_off_R9: assert property (@(posedge clk_i) disable iff (rst_i)
        !en_i && !load_i |=> $stable(count_q));

    // R2: enabled nonzero counter steps down by one
    assert_step_down_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        en_i && !load_i && !at_zero |=> count_q == $past(count_q) - 1'b1);

    // R3: expiry reloads the count
    assert_expiry_reload_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        timeout_o |=> count_q == $past(reload_i));

endmodule

// File: rtl/wdt_secure_clear.sv
module wdt_secure_clear
    import wdt_sc_pkg::*;
#(
    parameter int               CNT_W      = 16,
    parameter int               RELOAD_RST = 16'hFFFF,
    parameter logic [KEY_W-1:0] SEED_RST   = 8'h01
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             wr_en_i,
    input  logic [1:0]       wr_addr_i,
    input  logic [CNT_W-1:0] wr_data_i,
    output logic             rst_req_o,
    output logic [1:0]       cause_o,
    output logic [CNT_W-1:0] count_o
);

    logic [CNT_W-1:0] reload;
    wdt_ctrl_t        ctrl;
    logic             start, seed_we, key_we, plain_clear;
    logic [KEY_W-1:0] wbyte;
    logic             key_ok, key_fault;
    logic             timeout;
    logic             load;
    logic             req_q;
    wdt_cause_t       cause_q;

    wdt_sc_regs #(.CNT_W(CNT_W), .RELOAD_RST(RELOAD_RST)) u_regs (
        .clk_i        (clk_i),
        .rst_i        (rst_i),
        .wr_en_i      (wr_en_i),
        .wr_addr_i    (wr_addr_i),
        .wr_data_i    (wr_data_i),
        .reload_o     (reload),
        .ctrl_o       (ctrl),
        .start_o      (start),
        .seed_we_o    (seed_we),
        .key_we_o     (key_we),
        .plain_clear_o(plain_clear),
        .byte_o       (wbyte)
    );

    wdt_sc_keygen #(.SEED_RST(SEED_RST)) u_keygen (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .seed_we_i  (seed_we),
        .key_we_i   (key_we),
        .byte_i     (wbyte),
        .key_ok_o   (key_ok),
        .key_fault_o(key_fault)
    );

    assign load = start || plain_clear || key_ok;

    wdt_sc_counter #(.CNT_W(CNT_W)) u_counter (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .en_i     (ctrl.enable),
        .load_i   (load),
        .reload_i (reload),
        .count_o  (count_o),
        .timeout_o(timeout)
    );

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            req_q   <= 1'b0;
            cause_q <= '0;
        end else begin
            req_q             <= (timeout || key_fault) && !req_q;
            cause_q.timeout   <= cause_q.timeout   || timeout;
            cause_q.key_fault <= cause_q.key_fault || key_fault;
        end
    end

    assign rst_req_o = req_q;
    assign cause_o   = cause_q;

    // R4: request is a single-cycle pulse
    assert_single_pulse_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        rst_req_o |=> !rst_req_o);

    // R7: a key fault with no pulse in flight produces a request
    assert_fault_requests_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        key_fault && !rst_req_o |=> rst_req_o);

    // R10: cause bits never clear on their own
    assert_timeout_sticky_R10: assert property (@(posedge clk_i) disable iff (rst_i)
        cause_o[0] |=> cause_o[0]);
    assert_fault_sticky_R10: assert property (@(posedge clk_i) disable iff (rst_i)
        cause_o[1] |=> cause_o[1]);

endmodule

// File: tb/test_wdt_secure_clear.sv
module test_wdt_secure_clear;

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en;
    logic [1:0]  wr_addr;
    logic [15:0] wr_data;
    logic        rst_req;
    logic [1:0]  cause;
    logic [15:0] count;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    typedef struct {
        string       tag;
        logic        req;
        logic [1:0]  cause;
        logic [15:0] cnt;
        bit          use_cnt;
    } exp_t;

    exp_t sb_q[$];

    always #4 clk = ~clk;

    wdt_secure_clear i_wdt_secure_clear (
        .clk_i    (clk),
        .rst_i    (rst),
        .wr_en_i  (wr_en),
        .wr_addr_i(wr_addr),
        .wr_data_i(wr_data),
        .rst_req_o(rst_req),
        .cause_o  (cause),
        .count_o  (count)
    );

    function automatic logic [7:0] nxt(input logic [7:0] s);
        return {s[6:0], s[7] ^ s[5] ^ s[4] ^ s[3]};
    endfunction

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic expect_out(input string tag, input logic rq, input logic [1:0] c,
                              input logic [15:0] n, input bit use_n);
        exp_t e;
        e.tag = tag; e.req = rq; e.cause = c; e.cnt = n; e.use_cnt = use_n;
        sb_q.push_back(e);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) tick();
        rst = 1'b0;
    endtask

    always @(negedge clk) begin
        while (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            checks++;
            if (rst_req !== e.req || cause !== e.cause || (e.use_cnt && count !== e.cnt)) begin
                fails++;
                $display("FAIL %s: req=%0b cause=%0b count=%0d expected req=%0b cause=%0b count=%0d",
                         e.tag, rst_req, cause, count, e.req, e.cause, e.cnt);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: run did not finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] k1, k2, k3;
        wr_en = 0; wr_addr = 0; wr_data = 0;
        do_reset();
        expect_out("R1 reset state", 0, 2'b00, 16'd0, 1);

        // Plain mode timeout path
        wr(2'd0, 16'd5);
        wr(2'd1, 16'h0001);
        expect_out("R2 enable loads reload", 0, 2'b00, 16'd5, 1);
        repeat (2) tick();
        expect_out("R2 decrement", 0, 2'b00, 16'd3, 1);
        repeat (3) tick();
        expect_out("R3 reached zero, no request yet", 0, 2'b00, 16'd0, 1);
        tick();
        expect_out("R3 timeout request and reload", 1, 2'b01, 16'd5, 1);
        tick();
        expect_out("R4 pulse is one cycle", 0, 2'b01, 16'd4, 1);
        tick();
        wr(2'd3, 16'h1234);
        expect_out("R5 plain clear reloads", 0, 2'b01, 16'd5, 1);

        // Disable: hold and ignore
        wr(2'd1, 16'h0000);
        expect_out("R9 disable edge last decrement", 0, 2'b01, 16'd4, 1);
        repeat (5) tick();
        expect_out("R9 count holds while disabled", 0, 2'b01, 16'd4, 1);
        wr(2'd3, 16'h00AB);
        expect_out("R9 clear ignored while disabled", 0, 2'b01, 16'd4, 1);
        tick();
        expect_out("R10 timeout cause stays set", 0, 2'b01, 16'd4, 1);

        // Keyed mode
        do_reset();
        k1 = nxt(8'h5A); k2 = nxt(k1); k3 = nxt(k2);
        wr(2'd2, 16'h005A);
        wr(2'd0, 16'd20);
        wr(2'd1, 16'h0003);
        expect_out("R2 keyed enable loads", 0, 2'b00, 16'd20, 1);
        repeat (3) tick();
        wr(2'd3, {8'h00, k1});
        expect_out("R6 matching key reloads", 0, 2'b00, 16'd20, 1);
        wr(2'd3, {8'h00, k1});
        expect_out("R7 replayed key faults with count left", 1, 2'b10, 16'd19, 1);
        tick();
        expect_out("R4 fault pulse one cycle", 0, 2'b10, 16'd18, 1);
        wr(2'd3, {8'h00, k2});
        expect_out("R7 mismatch did not advance LFSR", 0, 2'b10, 16'd20, 1);
        tick();
        expect_out("R6 accepted key no request", 0, 2'b10, 16'd19, 1);

        // Disabled keyed clears ignored, LFSR not stepped
        wr(2'd1, 16'h0002);
        wr(2'd3, {8'h00, k3});
        expect_out("R9 keyed clear ignored while disabled", 0, 2'b10, 16'd18, 1);
        wr(2'd3, 16'h0000);
        expect_out("R9 wrong key ignored while disabled", 0, 2'b10, 16'd18, 1);
        wr(2'd1, 16'h0003);
        repeat (2) tick();
        wr(2'd3, {8'h00, k3});
        expect_out("R9 LFSR unchanged by disabled writes", 0, 2'b10, 16'd20, 1);
        tick();
        expect_out("R9 no late request", 0, 2'b10, 16'd19, 1);

        // Zero seed
        do_reset();
        wr(2'd0, 16'd3);
        wr(2'd2, 16'h0000);
        expect_out("R8 zero seed faults while disabled", 1, 2'b10, 16'd0, 1);
        tick();
        wr(2'd1, 16'h0003);
        wr(2'd3, {8'h00, nxt(8'h01)});
        expect_out("R8 zero seed not loaded", 0, 2'b10, 16'd3, 1);
        repeat (3) tick();
        expect_out("R3 count at zero", 0, 2'b10, 16'd0, 1);
        tick();
        expect_out("R10 both causes accumulate", 1, 2'b11, 16'd3, 1);
        tick();
        expect_out("R4 end of pulse", 0, 2'b11, 16'd2, 1);
        wr(2'd2, 16'h00C3);
        wr(2'd3, {8'h00, nxt(8'hC3)});
        expect_out("R8 nonzero seed loads", 0, 2'b11, 16'd3, 1);

        tick();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule